// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two independent 32-bit down-counters behind a small register bus. One control register and one event status register are shared by both timers. Each timer has its own value and reload registers. Every timer has an enable, an auto-reload enable, a choice of step source and a 3-bit prescale exponent. The step source is either every clock or a fixed reference strobe. A timer steps once every 2^exponent source cycles. A step on a count of zero is an expiry: it sets a sticky flag, which is also the timer's interrupt level. After an expiry the timer either reloads or, in one-shot use, turns itself off.

Software builds a periodic tick of N steps by writing N-1 to both the reload and the value register and enabling auto-reload. For a free-running counter whose inverse rises, it writes all ones to both registers with auto-reload on. For a one-shot delay it writes the delay to the value register and then sets only the enable bit.

The register bus has no back-pressure. A write (`bus_wr` high) is taken in the cycle it is presented. `bus_rdata` shows the register addressed by `bus_addr` in that cycle, combinationally. The interrupt lines are plain levels.

Top module: `dual_dtimer`

## Requirements
- R1: After reset every register reads zero and both `irq` bits are low.
- R2: Registers sit at 0x00 control, 0x04 status, 0x10/0x14 timer 0 reload/value, 0x18/0x1C timer 1 reload/value. Other addresses read zero. Control and reload registers read back what was written. A value register reads the live count.
- R3: Control bits: bit 0 enable 0, bit 1 auto-reload 0, bit 2 enable 1, bit 3 auto-reload 1, bit 11 reference select 0, bit 12 reference select 1. The exponents are in bits 21:19 (timer 0) and 24:22 (timer 1).
- R4: An enabled timer steps once every 2^exponent source cycles. The source cycle is every clock when its select bit is 0, and every clock with `tick_ref` high when the select bit is 1.
- R5: A step on a nonzero count decrements the count. A step on zero sets the timer's flag and, with auto-reload on, loads the reload value. So N-1 in both registers gives an expiry every N steps.
- R6: With auto-reload off, an expiry clears the timer's enable bit in the control register and the count stays at zero.
- R7: Status bit 0 is timer 0's flag and bit 8 is timer 1's flag. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: A write to a value register shows one clock later, restarts that timer's prescale phase, and overrides a step in the same cycle.
- R9: `irq[t]` equals timer t's flag in every cycle.
- R10: A disabled timer keeps its count and its prescale phase.
- R11: A one-shot expiry in the same cycle as a control write leaves that timer's enable bit cleared, whatever the write carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken in its cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| tick_ref | input | 1 | Fixed-reference enable strobe, synchronous to clk |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 2 | Level interrupts, one per timer |

## Verification
Several functions can land in the same cycle. An expiry can meet a status write that clears its flag. A one-shot expiry can meet a control write that sets the enable again. A value write can meet a prescaled step. The bench forces each of these with a period-one auto-reload timer, or with a zero count and a zero exponent, and then issues the write in the exact cycle the step happens. It judges the outcome against a behavioural model, which gives set priority over clear, expiry over the enable write, and the value write over the step.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int NT     = 2;
  localparam int ADDR_W = 8;
  localparam int EXP_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h04;

  function automatic int en_bit(input int t);   return 2 * t;      endfunction
  function automatic int auto_bit(input int t); return 2 * t + 1;  endfunction
  function automatic int ref_bit(input int t);  return 11 + t;     endfunction
  function automatic int exp_lsb(input int t);  return 19 + 3 * t; endfunction
  function automatic int flag_bit(input int t); return 8 * t;      endfunction

  function automatic logic [ADDR_W-1:0] rld_addr(input int t);
    return ADDR_W'(16 + 8 * t);
  endfunction
  function automatic logic [ADDR_W-1:0] val_addr(input int t);
    return ADDR_W'(20 + 8 * t);
  endfunction
endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             restart,
  output logic             step
);
  localparam int PCW = (1 << EXP_W) - 1;

  logic [PCW-1:0] phase_q;
  logic [PCW-1:0] limit;

  assign limit = PCW'((32'd1 << exp_sel) - 32'd1);
  assign step  = run && src && !restart && (phase_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run && src) begin
      phase_q <= step ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/dtm_timer.sv
module dtm_timer #(
  parameter int CNT_W = 32,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             auto_rl,
  input  logic             use_ref,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             ref_tick,
  input  logic             val_wr,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic step;

  dtm_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .src     (use_ref ? ref_tick : 1'b1),
    .exp_sel (exp_sel),
    .restart (val_wr),
    .step    (step)
  );

  assign expire = step && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (val_wr) begin
      count <= wdata;
    end else if (step) begin
      if (count != '0)   count <= count - 1'b1;
      else if (auto_rl)  count <= reload;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reload <= '0;
    else if (rld_wr) reload <= wdata;
  end

  // R5: a step on a nonzero count lowers it by one
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    step && (count != '0) && !val_wr |=> count == $past(count) - 1'b1);

  // R5: an auto-reload expiry loads the reload value
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && auto_rl && !val_wr |=> count == $past(reload));

  // R8: a value write shows on the next clock
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> count == $past(wdata));

  // R10: a stopped timer keeps its count
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !val_wr |=> $stable(count));
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
  import dtm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              tick_ref,
  output logic [31:0]       bus_rdata,
  output logic [NT-1:0]     irq
);
  logic [31:0]      ctrl_q, ctrl_nx;
  logic [NT-1:0]    flag_q, flag_nx;
  logic [NT-1:0]    expire;
  logic [CNT_W-1:0] cnt_v [NT];
  logic [CNT_W-1:0] rld_v [NT];
  logic             ctrl_wr, stat_wr;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    dtm_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[en_bit(t)]),
      .auto_rl  (ctrl_q[auto_bit(t)]),
      .use_ref  (ctrl_q[ref_bit(t)]),
      .exp_sel  (ctrl_q[exp_lsb(t) +: EXP_W]),
      .ref_tick (tick_ref),
      .val_wr   (bus_wr && (bus_addr == val_addr(t))),
      .rld_wr   (bus_wr && (bus_addr == rld_addr(t))),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .count    (cnt_v[t]),
      .reload   (rld_v[t]),
      .expire   (expire[t])
    );

    // R6, R11: a one-shot expiry leaves the enable bit cleared
    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      expire[t] && !ctrl_q[auto_bit(t)] |=> !ctrl_q[en_bit(t)]);

    // R7: an expiry always leaves its flag set
    a_r7_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire[t] |=> flag_q[t]);

    // R7: writing zero clears the flag when no expiry competes
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && !bus_wdata[flag_bit(t)] && !expire[t] |=> !flag_q[t]);
  end

  always_comb begin
    ctrl_nx = ctrl_wr ? bus_wdata : ctrl_q;
    flag_nx = flag_q;
    for (int t = 0; t < NT; t++) begin
      if (stat_wr && !bus_wdata[flag_bit(t)]) flag_nx[t] = 1'b0;
      if (expire[t]) begin
        flag_nx[t] = 1'b1;
        if (!ctrl_q[auto_bit(t)]) ctrl_nx[en_bit(t)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      flag_q <= flag_nx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
    if (bus_addr == A_STAT)
      for (int t = 0; t < NT; t++) bus_rdata[flag_bit(t)] = flag_q[t];
    for (int t = 0; t < NT; t++) begin
      if (bus_addr == rld_addr(t)) bus_rdata = 32'(rld_v[t]);
      if (bus_addr == val_addr(t)) bus_rdata = 32'(cnt_v[t]);
    end
  end

  assign irq = flag_q;
endmodule

// File: tb/dual_dtimer_tb.sv
module dual_dtimer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic        tick_ref = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dual_dtimer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tick_ref(tick_ref), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_cnt [2], m_rld [2];
  int          m_pre [2];
  logic [1:0]  m_flag;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return {23'd0, m_flag[1], 7'd0, m_flag[0]};
      8'h10: return m_rld[0];
      8'h14: return m_cnt[0];
      8'h18: return m_rld[1];
      8'h1C: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_flag = '0;
      for (int t = 0; t < 2; t++) begin m_cnt[t] = '0; m_rld[t] = '0; m_pre[t] = 0; end
    end else begin
      logic [31:0] nctrl;
      logic [1:0]  nflag;
      nctrl = (bus_wr && bus_addr == 8'h00) ? bus_wdata : m_ctrl;
      nflag = m_flag;
      if (bus_wr && bus_addr == 8'h04)
        for (int t = 0; t < 2; t++) if (!bus_wdata[8*t]) nflag[t] = 1'b0;
      for (int t = 0; t < 2; t++) begin
        bit en, au, rs, step;
        int ex;
        en = m_ctrl[2*t]; au = m_ctrl[2*t+1]; rs = m_ctrl[11+t];
        ex = int'((m_ctrl >> (19 + 3*t)) & 32'd7);
        step = 0;
        if (bus_wr && bus_addr == 8'(20 + 8*t)) begin
          m_cnt[t] = bus_wdata; m_pre[t] = 0;
        end else begin
          if (en && (rs ? tick_ref : 1'b1)) begin
            if (m_pre[t] == (1 << ex) - 1) begin m_pre[t] = 0; step = 1; end
            else m_pre[t] = m_pre[t] + 1;
          end
          if (step) begin
            if (m_cnt[t] == 0) begin
              nflag[t] = 1'b1;
              if (au) m_cnt[t] = m_rld[t];
              else    nctrl[2*t] = 1'b0;
            end else m_cnt[t] = m_cnt[t] - 1;
          end
        end
        if (bus_wr && bus_addr == 8'(16 + 8*t)) m_rld[t] = bus_wdata;
      end
      m_ctrl = nctrl;
      m_flag = nflag;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare on every clock, after state has settled
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check($sformatf("rdata@%h", bus_addr), bus_rdata, m_read(bus_addr));
      check("irq (R9)", {30'd0, irq}, {30'd0, m_flag});
    end
  end

  // reference strobe: high every third cycle
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      tick_ref = (k % 3 == 0);
      k++;
    end
  end

  logic [7:0] rot [6] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C};
  int ri = 0;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = rot[ri % 6]; ri++;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(12);
    check("R1 irq after reset", {30'd0, irq}, 32'd0);

    cur_req = "R2";
    wr(8'h10, 32'h1234_5678); wr(8'h18, 32'hCAFE_0001);
    wr(8'h14, 32'd77); wr(8'h1C, 32'd5);
    wr(8'h00, 32'h00E0_0000); wr(8'h20, 32'hFFFF_FFFF);
    idle(2); bus_addr = 8'h20; idle(0);
    @(negedge clk); bus_addr = 8'h20;
    idle(8);

    cur_req = "R3";
    wr(8'h14, 32'd10); wr(8'h00, 32'h0010_0001);
    idle(60);
    cur_req = "R4";
    wr(8'h1C, 32'd20); wr(8'h00, 32'h0000_1004);
    idle(90);
    wr(8'h00, 32'h00C0_1004); wr(8'h1C, 32'd3);
    idle(120);

    cur_req = "R5";
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    wr(8'h10, 32'd4); wr(8'h14, 32'd4); wr(8'h00, 32'h0000_0003);
    idle(40);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF); wr(8'h00, 32'h0000_000F);
    idle(30);

    cur_req = "R7";
    wr(8'h00, 32'h0); wr(8'h10, 32'd0); wr(8'h14, 32'd0);
    wr(8'h00, 32'h0000_0003); idle(3);
    wr(8'h04, 32'h0); idle(2);
    wr(8'h00, 32'h0); wr(8'h1C, 32'd0); wr(8'h00, 32'h0000_000C); idle(3);
    wr(8'h00, 32'h0); idle(2);
    wr(8'h04, 32'h0000_0100); idle(3);
    wr(8'h04, 32'h0000_0001); idle(3);
    wr(8'h04, 32'h0); idle(3);

    cur_req = "R6";
    wr(8'h14, 32'd3); wr(8'h00, 32'h0000_0001); idle(12);
    wr(8'h1C, 32'd2); wr(8'h00, 32'h0008_0004); idle(30);
    wr(8'h04, 32'h0); idle(3);

    cur_req = "R11";
    wr(8'h14, 32'd0); wr(8'h00, 32'h0000_0001);
    wr(8'h00, 32'h0000_0001); wr(8'h00, 32'h0000_0001); idle(6);

    cur_req = "R8";
    wr(8'h10, 32'd9); wr(8'h14, 32'd9); wr(8'h00, 32'h0000_0003); idle(3);
    wr(8'h14, 32'd50); wr(8'h14, 32'd40); idle(5);
    wr(8'h00, 32'h0010_0003); idle(2); wr(8'h14, 32'd6); idle(30);

    cur_req = "R10";
    wr(8'h00, 32'h0); wr(8'h14, 32'd123); wr(8'h1C, 32'd456); idle(25);
    wr(8'h00, 32'h0000_1000); idle(10);

    cur_req = "R9";
    wr(8'h04, 32'h0); idle(4);
    finish_run();
  end
endmodule